// File: doc/BRIEF.md
# I2C Master Command Register Interface

This block is the host side of a byte-oriented I2C master. A processor reaches it through a small synchronous register bus: one port for control, one for status, two for the 16-bit bus clock divider, one for the byte to transmit and one for the last byte received. The host writes one-shot command bits for START, STOP, byte write and byte read. It also writes an acknowledge-select bit for reads. The block hands these commands, one step at a time, to a byte engine that handles the SCL/SDA signalling.

The steps run in a fixed order: START first, then the byte write, then the byte read, then STOP. Each command bit clears itself when the engine reports that its step is done. A byte read is captured into the receive register, and the slave's acknowledge is captured into status. Once no command bit is left, the block raises a level interrupt if the host has enabled it. Writing the interrupt-acknowledge bit clears that interrupt. Setting STOP together with the last read or write chains the STOP onto that byte, and the pair raises a single interrupt.

The byte engine handshake is a request/done pair. The block holds `eng_req` and `eng_op` steady until the engine pulses `eng_done` for one cycle. In that same cycle the engine presents the received byte and the acknowledge level it saw.

Top module: `i2cm_cmd_regs`

## Requirements
- R1: Reset clears every command bit, the interrupt, the interrupt enable and the acknowledge select, and sets the divider to 0xFFFF. After reset, control reads 0x00, status reads 0x00 and `irq` is low.
- R2: A write to offset 2 sets bits 7..0 of the divider and a write to offset 3 sets bits 15..8. `clk_div` shows the new value from the cycle after the write, and both bytes read back.
- R3: The control register at offset 0 reads back with these bits: 7 = acknowledge select (1 sends NACK after a read), 6 = start, 5 = stop, 4 = read, 3 = write, 1 = interrupt enable. Bit 2 is the interrupt acknowledge and always reads 0. Bit 0 reads 0.
- R4: A command bit written as 1 stays set while its step is pending or running, and clears in the cycle that the engine reports that step done. A write of 0 to a command bit does not cancel it.
- R5: A control write with the write bit set copies the transmit register (offset 4) into the shift register, and that byte goes to the engine. Later writes to offset 4 do not change the byte already loaded.
- R6: When a read step completes, the engine's byte appears in the receive register (offset 5). While the read runs, `eng_nack` equals the acknowledge-select bit.
- R7: Status (offset 1) bit 1 holds the acknowledge level the slave returned on the last write or read step (0 = acknowledged, 1 = not acknowledged). Status bit 0 is 1 while any command bit is set or a step is in flight.
- R8: A stop bit set together with the final write or read issues STOP straight after that byte, and the pair raises only one interrupt.
- R9: `irq` rises only after a step completes with no command bit left, and only if the interrupt enable was set at that moment. A control write with bit 2 set clears `irq` and leaves every pending command bit unchanged.
- R10: When several command bits are pending, the steps issue in the order START, write, read, STOP, and each step issues at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (3) | Register offset |
| bus_wdata | input | DW (8) | Write data |
| bus_rdata | output | DW (8) | Read data, valid the cycle after a read strobe |
| clk_div | output | 2*DW (16) | Bus clock divider |
| eng_req | output | 1 | Step request to the byte engine, held until done |
| eng_op | output | 2 | Step code: 0 start, 1 write, 2 read, 3 stop |
| eng_tx_byte | output | DW (8) | Shift register byte for a write step |
| eng_nack | output | 1 | Acknowledge level the master returns after a read |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_rx_byte | input | DW (8) | Byte received, valid with `eng_done` |
| eng_rx_nack | input | 1 | Slave acknowledge level, valid with `eng_done` |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives all four command bits in a single write and checks that exactly the steps START, write, read and STOP come out, in that order. A sequencer with the wrong priority, or one that reissues a step, fails the engine-side compare. For a combined read plus STOP, the bench counts rising edges of the interrupt. A design that signals after the byte and again after the STOP shows two edges. An interrupt acknowledge is written while a long write is still running, and a new transmit byte is written during that same transfer. A design that lets the acknowledge disturb pending bits loses the write bit in the control readback, and one that sends the live transmit register instead of the loaded copy puts the wrong byte on the engine. A completion with the interrupt enable clear is also run, and it must leave the interrupt low.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } i2c_op_e;

  localparam int OPS = 4;

  // control register bit positions
  localparam int CB_NACK  = 7;
  localparam int CB_START = 6;
  localparam int CB_STOP  = 5;
  localparam int CB_RD    = 4;
  localparam int CB_WR    = 3;
  localparam int CB_IACK  = 2;
  localparam int CB_IEN   = 1;

  // status register bit positions
  localparam int SB_RXNACK = 1;
  localparam int SB_BUSY   = 0;

  // register offsets
  localparam int RA_CTRL = 0;
  localparam int RA_STAT = 1;
  localparam int RA_DIVL = 2;
  localparam int RA_DIVH = 3;
  localparam int RA_TXD  = 4;
  localparam int RA_RXD  = 5;

  function automatic int ctrl_bit_of(input int op);
    case (op)
      0:       return CB_START;
      1:       return CB_WR;
      2:       return CB_RD;
      default: return CB_STOP;
    endcase
  endfunction

endpackage

// File: rtl/i2cm_reg_file.sv
module i2cm_reg_file
  import i2cm_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic [OPS-1:0]  pend,
  input  logic            busy,
  input  logic [DW-1:0]   rxd,
  input  logic            rxnack,
  output logic [DW-1:0]   bus_rdata,
  output logic [2*DW-1:0] clk_div,
  output logic [DW-1:0]   tx_data,
  output logic            ien,
  output logic            nack_sel,
  output logic            ctrl_wr,
  output logic            iack
);

  localparam int DIVW  = 2 * DW;
  localparam int LANES = DIVW / DW;

  logic            wr_en;
  logic            rd_en;
  logic [DIVW-1:0] div_q;
  logic [DW-1:0]   rd_mux;

  assign wr_en   = bus_sel & bus_we;
  assign rd_en   = bus_sel & ~bus_we;
  assign ctrl_wr = wr_en & (bus_addr == AW'(RA_CTRL));
  assign iack    = ctrl_wr & bus_wdata[CB_IACK];
  assign clk_div = div_q;

  // divider byte lanes, low lane at the lower offset
  for (genvar l = 0; l < LANES; l++) begin : g_div
    always_ff @(posedge clk) begin
      if (rst) begin
        div_q[l*DW +: DW] <= '1;
      end else if (wr_en && bus_addr == AW'(RA_DIVL + l)) begin
        div_q[l*DW +: DW] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien      <= 1'b0;
      nack_sel <= 1'b0;
      tx_data  <= '0;
    end else begin
      if (ctrl_wr) begin
        ien      <= bus_wdata[CB_IEN];
        nack_sel <= bus_wdata[CB_NACK];
      end
      if (wr_en && bus_addr == AW'(RA_TXD)) begin
        tx_data <= bus_wdata;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (int'(bus_addr))
      RA_CTRL: begin
        rd_mux[CB_NACK]  = nack_sel;
        rd_mux[CB_START] = pend[OP_START];
        rd_mux[CB_STOP]  = pend[OP_STOP];
        rd_mux[CB_RD]    = pend[OP_READ];
        rd_mux[CB_WR]    = pend[OP_WRITE];
        rd_mux[CB_IEN]   = ien;
      end
      RA_STAT: begin
        rd_mux[SB_RXNACK] = rxnack;
        rd_mux[SB_BUSY]   = busy;
      end
      RA_DIVL: rd_mux = div_q[DW-1:0];
      RA_DIVH: rd_mux = div_q[DIVW-1:DW];
      RA_TXD:  rd_mux = tx_data;
      RA_RXD:  rd_mux = rxd;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_en) begin
      bus_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/i2cm_sequencer.sv
module i2cm_sequencer
  import i2cm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ctrl_wr,
  input  logic [DW-1:0]  wdata,
  input  logic [DW-1:0]  tx_data,
  input  logic           eng_done,
  input  logic [DW-1:0]  eng_rx_byte,
  input  logic           eng_rx_nack,
  output logic           eng_req,
  output i2c_op_e        eng_op,
  output logic [DW-1:0]  shift_q,
  output logic [OPS-1:0] pend,
  output logic           busy,
  output logic [DW-1:0]  rxd_q,
  output logic           rxnack_q,
  output logic           finish
);

  logic [OPS-1:0] set_v;
  logic [OPS-1:0] clr_v;
  logic           step_done;
  logic           any_pend;
  i2c_op_e        pick;

  assign step_done = eng_req & eng_done;
  assign any_pend  = |pend;
  assign busy      = any_pend | eng_req;
  assign finish    = step_done & ((pend & ~clr_v) == '0);

  // one pending flag per step
  for (genvar g = 0; g < OPS; g++) begin : g_cmd
    localparam int CB = ctrl_bit_of(g);
    assign set_v[g] = ctrl_wr & wdata[CB];
    assign clr_v[g] = step_done & (eng_op == i2c_op_e'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        pend[g] <= 1'b0;
      end else begin
        pend[g] <= (pend[g] & ~clr_v[g]) | set_v[g];
      end
    end
  end

  // fixed priority: start, write, read, stop
  always_comb begin
    pick = OP_STOP;
    if (pend[OP_START])      pick = OP_START;
    else if (pend[OP_WRITE]) pick = OP_WRITE;
    else if (pend[OP_READ])  pick = OP_READ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eng_req <= 1'b0;
      eng_op  <= OP_START;
    end else if (!eng_req) begin
      if (any_pend) begin
        eng_req <= 1'b1;
        eng_op  <= pick;
      end
    end else if (eng_done) begin
      eng_req <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q  <= '0;
      rxd_q    <= '0;
      rxnack_q <= 1'b0;
    end else begin
      if (set_v[OP_WRITE]) shift_q <= tx_data;
      if (clr_v[OP_READ]) rxd_q <= eng_rx_byte;
      if (clr_v[OP_READ] || clr_v[OP_WRITE]) rxnack_q <= eng_rx_nack;
    end
  end

endmodule

// File: rtl/i2cm_irq.sv
module i2cm_irq (
  input  logic clk,
  input  logic rst,
  input  logic ien,
  input  logic finish,
  input  logic iack,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else if (finish && ien) begin
      irq <= 1'b1;
    end else if (iack) begin
      irq <= 1'b0;
    end
  end

endmodule

// File: rtl/i2cm_cmd_regs.sv
module i2cm_cmd_regs
  import i2cm_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic [2*DW-1:0] clk_div,
  output logic            eng_req,
  output logic [1:0]      eng_op,
  output logic [DW-1:0]   eng_tx_byte,
  output logic            eng_nack,
  input  logic            eng_done,
  input  logic [DW-1:0]   eng_rx_byte,
  input  logic            eng_rx_nack,
  output logic            irq
);

  logic [OPS-1:0] pend_w;
  logic           busy_w;
  logic [DW-1:0]  rxd_w;
  logic           rxnack_w;
  logic [DW-1:0]  tx_data_w;
  logic           ien_q;
  logic           nack_w;
  logic           ctrl_wr_w;
  logic           iack_w;
  logic           finish_w;
  i2c_op_e        op_w;

  assign eng_op   = op_w;
  assign eng_nack = nack_w;

  i2cm_reg_file #(.DW(DW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pend      (pend_w),
    .busy      (busy_w),
    .rxd       (rxd_w),
    .rxnack    (rxnack_w),
    .bus_rdata (bus_rdata),
    .clk_div   (clk_div),
    .tx_data   (tx_data_w),
    .ien       (ien_q),
    .nack_sel  (nack_w),
    .ctrl_wr   (ctrl_wr_w),
    .iack      (iack_w)
  );

  i2cm_sequencer #(.DW(DW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .ctrl_wr     (ctrl_wr_w),
    .wdata       (bus_wdata),
    .tx_data     (tx_data_w),
    .eng_done    (eng_done),
    .eng_rx_byte (eng_rx_byte),
    .eng_rx_nack (eng_rx_nack),
    .eng_req     (eng_req),
    .eng_op      (op_w),
    .shift_q     (eng_tx_byte),
    .pend        (pend_w),
    .busy        (busy_w),
    .rxd_q       (rxd_w),
    .rxnack_q    (rxnack_w),
    .finish      (finish_w)
  );

  i2cm_irq u_irq (
    .clk    (clk),
    .rst    (rst),
    .ien    (ien_q),
    .finish (finish_w),
    .iack   (iack_w),
    .irq    (irq)
  );

endmodule

// File: rtl/i2cm_cmd_regs_chk.sv
module i2cm_cmd_regs_chk (
  input logic        clk,
  input logic        rst,
  input logic        eng_req,
  input logic        eng_done,
  input logic [1:0]  eng_op,
  input logic        irq,
  input logic        ien,
  input logic        busy,
  input logic [15:0] clk_div,
  input logic [3:0]  pend
);

  AST_DIV_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> clk_div == 16'hFFFF); // R1

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    eng_req && !eng_done |=> eng_req && $stable(eng_op)); // R4

  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (rst)
    eng_req && eng_done |=> !eng_req); // R10

  AST_BUSY_IN_STEP: assert property (@(posedge clk) disable iff (rst)
    eng_req |-> busy); // R7

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(eng_done && ien)); // R9

  AST_STOP_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_req) && eng_op == 2'd3 |-> $past(pend[2:0] == 3'b000)); // R8

endmodule

bind i2cm_cmd_regs i2cm_cmd_regs_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .eng_req  (eng_req),
  .eng_done (eng_done),
  .eng_op   (eng_op),
  .irq      (irq),
  .ien      (ien_q),
  .busy     (busy_w),
  .clk_div  (clk_div),
  .pend     (pend_w)
);

// File: tb/sim_i2cm_cmd_regs.sv
module sim_i2cm_cmd_regs;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] clk_div;
  logic        eng_req;
  logic [1:0]  eng_op;
  logic [7:0]  eng_tx_byte;
  logic        eng_nack;
  logic        eng_done = 1'b0;
  logic [7:0]  eng_rx_byte = '0;
  logic        eng_rx_nack = 1'b0;
  logic        irq;

  always #4 clk = ~clk;

  i2cm_cmd_regs u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .clk_div(clk_div), .eng_req(eng_req), .eng_op(eng_op),
    .eng_tx_byte(eng_tx_byte), .eng_nack(eng_nack), .eng_done(eng_done),
    .eng_rx_byte(eng_rx_byte), .eng_rx_nack(eng_rx_nack), .irq(irq)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  task automatic chk(input int act, input int exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // behavioural byte engine
  int   exp_q[$];
  int   eng_delay = 4;
  int   cnt = 0;
  bit   active = 0;
  int   cur_op = 0;
  logic [7:0] rx_byte_v = 8'h00;
  logic       rx_nack_v = 1'b0;
  logic       last_rd_nack = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      eng_done = 1'b0;
      active   = 0;
    end else if (eng_done) begin
      eng_done = 1'b0;
    end else if (active) begin
      cnt--;
      if (cnt == 0) begin
        eng_rx_byte = rx_byte_v;
        eng_rx_nack = rx_nack_v;
        eng_done    = 1'b1;
        active      = 0;
      end
    end else if (eng_req) begin
      int code;
      active = 1;
      cnt    = eng_delay;
      cur_op = int'(eng_op);
      code   = cur_op * 256 + ((cur_op == 1) ? int'(eng_tx_byte) : 0);
      if (cur_op == 2) last_rd_nack = eng_nack;
      if (exp_q.size() == 0) chk(code, -1, "R10 unexpected step");
      else chk(code, exp_q.pop_front(), "R10/R5 step order and byte");
    end
  end

  // reference model of pending steps and interrupt
  bit [3:0] m_pend = '0;
  bit       m_irq = 0;
  bit       m_ien = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_pend = '0; m_irq = 0; m_ien = 0;
    end else begin
      bit fin;
      fin = 0;
      if (eng_done) begin
        m_pend[cur_op] = 1'b0;
        if (m_pend == 4'b0000 && m_ien) fin = 1;
      end
      if (bus_sel && bus_we && bus_addr == 3'd0) begin
        if (bus_wdata[2]) m_irq = 0;
        if (bus_wdata[6]) m_pend[0] = 1'b1;
        if (bus_wdata[3]) m_pend[1] = 1'b1;
        if (bus_wdata[4]) m_pend[2] = 1'b1;
        if (bus_wdata[5]) m_pend[3] = 1'b1;
        m_ien = bus_wdata[1];
      end
      if (fin) m_irq = 1;
    end
  end

  int rises = 0;
  bit prev_irq = 0;
  always @(negedge clk) begin
    if (!rst) begin
      chk(int'(irq), int'(m_irq), "R9 irq against model");
      if (irq && !prev_irq) rises++;
      prev_irq = irq;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL R4 watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic bus_write(input int a, input int d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input int a, output int d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 3'(a);
    @(negedge clk);
    d = int'(bus_rdata);
    bus_sel = 1'b0;
  endtask

  task automatic wait_irq(input string tag);
    int n;
    n = 0;
    while (!irq && n < 500) begin
      @(negedge clk);
      n++;
    end
    chk(int'(irq), 1, tag);
  endtask

  task automatic wait_idle(input string tag);
    int s;
    int n;
    n = 0;
    bus_read(1, s);
    while ((s & 1) != 0 && n < 300) begin
      bus_read(1, s);
      n++;
    end
    chk(s & 1, 0, tag);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_read(0, v); chk(v, 8'h00, "R1 control after reset");
    bus_read(1, v); chk(v, 8'h00, "R1 status after reset");
    chk(int'(clk_div), 16'hFFFF, "R1 divider after reset");
    chk(int'(irq), 0, "R1 irq after reset");

    // R2 divider bytes
    bus_write(2, 8'h34);
    bus_write(3, 8'h12);
    chk(int'(clk_div), 16'h1234, "R2 divider port");
    bus_read(2, v); chk(v, 8'h34, "R2 divider low readback");
    bus_read(3, v); chk(v, 8'h12, "R2 divider high readback");

    // R3 control readback, iack reads 0
    bus_write(0, 8'h86);
    bus_read(0, v); chk(v, 8'h82, "R3 control readback");
    bus_write(0, 8'h02);

    // R4/R10 start + write of an address byte
    bus_write(4, 8'hA4);
    exp_q.push_back(0 * 256);
    exp_q.push_back(1 * 256 + 8'hA4);
    rx_nack_v = 1'b0;
    bus_write(0, 8'h4A);
    bus_read(0, v); chk(v, 8'h4A, "R4 bits pending during step");
    bus_read(1, v); chk(v & 1, 1, "R7 busy during step");
    wait_irq("R9 irq after address byte");
    bus_read(0, v); chk(v, 8'h02, "R4 start and write cleared");
    bus_read(1, v); chk(v, 8'h00, "R7 ack seen, idle");
    chk(exp_q.size(), 0, "R10 start then write issued");
    bus_write(0, 8'h06);
    chk(int'(irq), 0, "R9 iack clears irq");
    bus_read(0, v); chk(v, 8'h02, "R3 enable kept after iack");

    // R5 loaded byte immune to later transmit writes; R9 iack keeps pending
    bus_write(4, 8'h5C);
    exp_q.push_back(1 * 256 + 8'h5C);
    rx_nack_v = 1'b1;
    eng_delay = 12;
    bus_write(0, 8'h0A);
    bus_write(4, 8'hEE);
    bus_write(0, 8'h06);
    bus_read(0, v); chk(v, 8'h0A, "R9 iack leaves write pending");
    wait_irq("R9 irq after data byte");
    bus_read(1, v); chk(v, 8'h02, "R7 slave nack in status");
    chk(exp_q.size(), 0, "R5 loaded byte sent");
    bus_write(0, 8'h06);
    eng_delay = 4;

    // R6 read with nack select
    exp_q.push_back(2 * 256);
    rx_byte_v = 8'h3C;
    rx_nack_v = 1'b0;
    bus_write(0, 8'h92);
    wait_irq("R9 irq after read");
    chk(int'(last_rd_nack), 1, "R6 nack driven during read");
    bus_read(5, v); chk(v, 8'h3C, "R6 received byte");
    bus_read(0, v); chk(v, 8'h82, "R4 read bit cleared");
    bus_write(0, 8'h06);

    // R8 read chained into stop, single interrupt
    exp_q.push_back(2 * 256);
    exp_q.push_back(3 * 256);
    rx_byte_v = 8'h7E;
    rises = 0;
    bus_write(0, 8'h32);
    wait_irq("R8 irq after read+stop");
    wait_idle("R8 idle after stop");
    chk(rises, 1, "R8 one interrupt for read+stop");
    chk(exp_q.size(), 0, "R8 stop followed read");
    bus_read(5, v); chk(v, 8'h7E, "R6 second received byte");
    bus_write(0, 8'h06);

    // R10 all four commands at once
    exp_q.push_back(0 * 256);
    exp_q.push_back(1 * 256 + 8'hEE);
    exp_q.push_back(2 * 256);
    exp_q.push_back(3 * 256);
    rises = 0;
    bus_write(0, 8'h7A);
    wait_irq("R10 irq after full sequence");
    wait_idle("R10 idle after full sequence");
    chk(rises, 1, "R8 single interrupt for sequence");
    chk(exp_q.size(), 0, "R10 all four steps issued");
    bus_write(0, 8'h06);

    // R9 completion with enable clear
    bus_write(0, 8'h04);
    exp_q.push_back(1 * 256 + 8'hEE);
    bus_write(0, 8'h08);
    wait_idle("R9 idle with enable clear");
    chk(int'(irq), 0, "R9 no irq when disabled");
    chk(exp_q.size(), 0, "R4 write step ran");

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule